// File: doc/BRIEF.md
# Halt and Shutdown Indication Controller

This block sits between a processor core and its external bus. When the core asks to stop, it runs one special bus cycle that tells the outside world whether the core is entering the halted state or has shut down. It then keeps the core stopped until an allowed wake-up event arrives. Both kinds of stop use the same cycle-definition code on the bus. Only the byte lane that is addressed differs, so external logic can tell them apart from the byte enables alone.

The cycle starts with a one-clock address strobe. The cycle-definition lines, the address and the byte enables stay stable until the active-low ready input is sampled low in the second bus state. Only after that does the block report itself halted. A shutdown also ends in the halted condition and follows the same wake-up rules. While halted, the block watches for three wake-up sources:

- a rising edge on the non-maskable input;
- the maskable input while the interrupt-enable flag is set;
- a reset-wake request.

It leaves the halted state with a one-clock resume pulse that is tagged with the winning source.

Top module: `halt_shutdown_ctrl`

## Requirements
- R1: One clock after a stop request is accepted in the idle state, `ads_n` is low for exactly one clock. From that clock until the cycle ends, `mio`=1, `dc`=0 and `wr`=1. Outside a cycle all three are 0 and `be_n` is all ones.
- R2: A halt cycle drives `addr_hi` (address bits 31..2) to zero and `be_n`=4'b1011, so that only byte enable 2 is active.
- R3: A shutdown cycle drives `addr_hi` to zero and `be_n`=4'b1110, so that only byte enable 0 is active.
- R4: If `halt_req` and `shut_req` are both high in the same clock, the cycle is a shutdown cycle.
- R5: In the second bus state, the cycle waits for as long as `rdy_n` is sampled high. During that wait, `halted` stays 0 and the address and byte enables hold their values.
- R6: `halted` becomes 1 on the clock edge that samples `rdy_n` low in the second bus state. Stop requests that arrive while a cycle is running or while halted start no new cycle.
- R7: While halted, `intr` high with `if_flag` set wakes the block. `intr` high with `if_flag` clear leaves it halted.
- R8: While halted, a low-to-high transition of `nmi` wakes the block. An `nmi` that is already high and stays high does not wake it.
- R9: `reset_wake` wakes a halted block and wins over `nmi` and `intr` in the same clock. Outside the halted state it cancels any cycle in progress and returns the block to idle on the next clock, with no resume pulse.
- R10: A wake-up clears `halted` and raises `resume` for exactly one clock on the next edge. On that clock, `resume_src` reads 2'b01 for the maskable source, 2'b10 for the non-maskable source and 2'b11 for reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| halt_req | input | 1 | Core asks to enter the halted state |
| shut_req | input | 1 | Core reports shutdown |
| rdy_n | input | 1 | Active-low bus cycle completion |
| intr | input | 1 | Maskable interrupt level |
| if_flag | input | 1 | Interrupt-enable flag from the core |
| nmi | input | 1 | Non-maskable interrupt (edge-sensitive) |
| reset_wake | input | 1 | Core reset request used as a wake-up source |
| ads_n | output | 1 | Active-low address strobe, one clock per cycle |
| mio | output | 1 | Memory/IO cycle-definition line |
| dc | output | 1 | Data/control cycle-definition line |
| wr | output | 1 | Write/read cycle-definition line |
| addr_hi | output | ADDR_W-2 | Address bits above the byte lanes |
| be_n | output | DATA_W/8 | Active-low byte enables |
| data_out | output | DATA_W | Data bus during the cycle (content is unspecified) |
| halted | output | 1 | Core is held halted |
| resume | output | 1 | One-clock wake-up pulse |
| resume_src | output | 2 | Source of the wake-up, valid with `resume` |

## Verification
Every result appears one clock edge after the input that causes it:

- The strobe and the lane selection appear one edge after the request.
- The strobe clears on the following edge.
- `halted` rises on the edge that samples `rdy_n` low in the second bus state.
- The resume pulse and its source appear on the edge after the wake-up input.

The bench drives inputs on the falling edge and compares outputs after exactly one rising edge per step. A late or early output is therefore seen as a mismatch. Hold-type behaviour is checked over further single steps: a stalled ready, a masked interrupt and a steady-high `nmi`. Each of those steps must leave the outputs unchanged.

// File: rtl/hsi_pkg.sv
package hsi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_T1   = 2'b01,
        ST_T2   = 2'b10,
        ST_HALT = 2'b11
    } hsi_state_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'b00,
        SRC_INTR  = 2'b01,
        SRC_NMI   = 2'b10,
        SRC_RESET = 2'b11
    } hsi_src_e;

endpackage

// File: rtl/hsi_wake_detect.sv
module hsi_wake_detect
    import hsi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     halted,
    input  logic     intr,
    input  logic     if_flag,
    input  logic     nmi,
    input  logic     reset_wake,
    output logic     wake,
    output hsi_src_e wake_src
);

    logic nmi_prev_q, nmi_prev_d;
    logic nmi_rise;

    always_comb begin
        nmi_prev_d = nmi;
        nmi_rise   = nmi && !nmi_prev_q;
        if (reset_wake) begin
            wake_src = SRC_RESET;
        end else if (nmi_rise) begin
            wake_src = SRC_NMI;
        end else if (intr && if_flag) begin
            wake_src = SRC_INTR;
        end else begin
            wake_src = SRC_NONE;
        end
        wake = halted && (wake_src != SRC_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_prev_q <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_prev_d;
        end
    end

    // R8: an nmi level that was already high one clock earlier never selects the non-maskable source
    p_nmi_level_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(nmi) && !reset_wake) |-> (wake_src != SRC_NMI));

endmodule

// File: rtl/hsi_cycle_sel.sv
module hsi_cycle_sel #(
    parameter int ADDR_W    = 32,
    parameter int BE_W      = 4,
    parameter int HALT_BYTE = 2,
    parameter int SHUT_BYTE = 0
) (
    input  logic                              bus_on,
    input  logic                              is_shut,
    output logic [ADDR_W-$clog2(BE_W)-1:0]    addr_hi,
    output logic [BE_W-1:0]                   be_n
);

    localparam int HI_W = ADDR_W - $clog2(BE_W);

    assign addr_hi = '0;

    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        localparam bit LANE_HALT = (g == HALT_BYTE);
        localparam bit LANE_SHUT = (g == SHUT_BYTE);
        assign be_n[g] = !(bus_on && (is_shut ? LANE_SHUT : LANE_HALT));
    end

    // R1: outside a cycle no byte lane is enabled
    p_idle_lanes_r1: assert final (bus_on || (be_n == {BE_W{1'b1}}));
    // R2/R3: during a cycle exactly one lane is enabled and the upper address is zero
    p_one_lane_r2: assert final (!bus_on || (($countones(~be_n) == 1) && (addr_hi == {HI_W{1'b0}})));

endmodule

// File: rtl/halt_shutdown_ctrl.sv
module halt_shutdown_ctrl
    import hsi_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int HALT_BYTE = 2,
    parameter int SHUT_BYTE = 0
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   halt_req,
    input  logic                                   shut_req,
    input  logic                                   rdy_n,
    input  logic                                   intr,
    input  logic                                   if_flag,
    input  logic                                   nmi,
    input  logic                                   reset_wake,
    output logic                                   ads_n,
    output logic                                   mio,
    output logic                                   dc,
    output logic                                   wr,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0]     addr_hi,
    output logic [DATA_W/8-1:0]                    be_n,
    output logic [DATA_W-1:0]                      data_out,
    output logic                                   halted,
    output logic                                   resume,
    output logic [1:0]                             resume_src
);

    localparam int BE_W = DATA_W / 8;
    localparam int HI_W = ADDR_W - $clog2(BE_W);
    localparam logic [BE_W-1:0] HALT_BE_N = ~(BE_W'(1) << HALT_BYTE);
    localparam logic [BE_W-1:0] SHUT_BE_N = ~(BE_W'(1) << SHUT_BYTE);

    typedef struct packed {
        hsi_state_e state;
        logic       is_shut;
        logic       ads_n;
        logic       resume;
        hsi_src_e   src;
    } ctrl_regs_t;

    ctrl_regs_t q, d;
    logic       wake;
    hsi_src_e   wake_src;
    logic       bus_on;

    assign bus_on = (q.state == ST_T1) || (q.state == ST_T2);

    hsi_wake_detect u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .halted     (q.state == ST_HALT),
        .intr       (intr),
        .if_flag    (if_flag),
        .nmi        (nmi),
        .reset_wake (reset_wake),
        .wake       (wake),
        .wake_src   (wake_src)
    );

    hsi_cycle_sel #(
        .ADDR_W    (ADDR_W),
        .BE_W      (BE_W),
        .HALT_BYTE (HALT_BYTE),
        .SHUT_BYTE (SHUT_BYTE)
    ) u_sel (
        .bus_on  (bus_on),
        .is_shut (q.is_shut),
        .addr_hi (addr_hi),
        .be_n    (be_n)
    );

    always_comb begin
        d        = q;
        d.ads_n  = 1'b1;
        d.resume = 1'b0;
        d.src    = SRC_NONE;
        unique case (q.state)
            ST_IDLE: begin
                if (halt_req || shut_req) begin
                    d.state   = ST_T1;
                    d.is_shut = shut_req;
                    d.ads_n   = 1'b0;
                end
            end
            ST_T1: begin
                d.state = ST_T2;
            end
            ST_T2: begin
                if (!rdy_n) begin
                    d.state = ST_HALT;
                end
            end
            ST_HALT: begin
                if (wake) begin
                    d.state  = ST_IDLE;
                    d.resume = 1'b1;
                    d.src    = wake_src;
                end
            end
            default: d.state = ST_IDLE;
        endcase
        if (reset_wake && (q.state != ST_HALT)) begin
            d.state = ST_IDLE;
            d.ads_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, is_shut: 1'b0, ads_n: 1'b1, resume: 1'b0, src: SRC_NONE};
        end else begin
            q <= d;
        end
    end

    assign ads_n      = q.ads_n;
    assign mio        = bus_on;
    assign dc         = 1'b0;
    assign wr         = bus_on;
    assign data_out   = '0;
    assign halted     = (q.state == ST_HALT);
    assign resume     = q.resume;
    assign resume_src = q.src;

    // R1: the strobe lasts one clock
    p_strobe_one_clock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> ads_n);
    // R1: cycle definition while the strobe is low
    p_cycle_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |-> (mio && !dc && wr));
    // R2: halt lane selection
    p_halt_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_n && !be_n[HALT_BYTE]) |-> ((be_n == HALT_BE_N) && (addr_hi == {HI_W{1'b0}})));
    // R3: shutdown lane selection
    p_shut_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_n && !be_n[SHUT_BYTE]) |-> ((be_n == SHUT_BE_N) && (addr_hi == {HI_W{1'b0}})));
    // R4: a joint request yields a shutdown cycle
    p_shut_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !bus_on && halt_req && shut_req && !reset_wake) |=> (be_n == SHUT_BE_N));
    // R5: a stalled cycle keeps its lanes
    p_hold_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mio && !ads_n) |=> $stable(be_n));
    // R6: halted only after ready
    p_halt_after_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(!rdy_n));
    // R7: masked interrupt does not wake
    p_masked_intr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !if_flag && !nmi && !reset_wake) |=> halted);
    // R9: reset wins while halted
    p_reset_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && reset_wake) |=> (resume && (resume_src == 2'b11)));
    // R10: one-clock pulse with a source, leaving the halted state
    p_resume_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !resume);
    p_resume_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> ((resume_src != 2'b00) && !halted && $past(halted)));

endmodule

// File: tb/tb_halt_shutdown_ctrl.sv
module tb_halt_shutdown_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt_req = 1'b0, shut_req = 1'b0, rdy_n = 1'b1;
    logic        intr = 1'b0, if_flag = 1'b0, nmi = 1'b0, reset_wake = 1'b0;
    logic        ads_n, mio, dc, wr, halted, resume;
    logic [29:0] addr_hi;
    logic [3:0]  be_n;
    logic [31:0] data_out;
    logic [1:0]  resume_src;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    halt_shutdown_ctrl dut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .shut_req(shut_req),
        .rdy_n(rdy_n), .intr(intr), .if_flag(if_flag), .nmi(nmi),
        .reset_wake(reset_wake), .ads_n(ads_n), .mio(mio), .dc(dc), .wr(wr),
        .addr_hi(addr_hi), .be_n(be_n), .data_out(data_out), .halted(halted),
        .resume(resume), .resume_src(resume_src)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // run a stop cycle to the halted state; req: 1 halt, 2 shutdown, 3 both
    task automatic enter_halt(input int req, input logic [3:0] exp_be, input string tag);
        halt_req = req[0];
        shut_req = req[1];
        step();
        halt_req = 1'b0;
        shut_req = 1'b0;
        chk({tag, " R1 strobe"}, ads_n, 0);
        chk({tag, " R1 code"}, {mio, dc, wr}, 3'b101);
        chk({tag, " R2/R3 be"}, be_n, exp_be);
        chk({tag, " R2/R3 addr"}, addr_hi, 0);
        step();
        chk({tag, " R1 strobe end"}, ads_n, 1);
        step();
        chk({tag, " R5 wait halted"}, halted, 0);
        chk({tag, " R5 wait be"}, be_n, exp_be);
        rdy_n = 1'b0;
        step();
        rdy_n = 1'b1;
        chk({tag, " R6 halted"}, halted, 1);
        chk({tag, " R1 idle code"}, {mio, be_n}, 5'b01111);
    endtask

    typedef struct packed {
        logic [1:0] req;
        logic [3:0] be;
        logic [1:0] wake;
        logic       mask_first;
        logic [1:0] src;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{req: 2'd1, be: 4'b1011, wake: 2'd1, mask_first: 1'b0, src: 2'b01},
        '{req: 2'd2, be: 4'b1110, wake: 2'd2, mask_first: 1'b1, src: 2'b10},
        '{req: 2'd3, be: 4'b1110, wake: 2'd3, mask_first: 1'b0, src: 2'b11},
        '{req: 2'd1, be: 4'b1011, wake: 2'd2, mask_first: 1'b1, src: 2'b10},
        '{req: 2'd2, be: 4'b1110, wake: 2'd1, mask_first: 1'b0, src: 2'b01},
        '{req: 2'd1, be: 4'b1011, wake: 2'd3, mask_first: 1'b1, src: 2'b11}
    };

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        step();
        step();
        chk("R1 reset strobe", ads_n, 1);
        chk("R1 reset code", {mio, dc, wr}, 0);
        chk("R1 reset be", be_n, 4'hF);
        chk("R6 reset halted", halted, 0);
        chk("R10 reset resume", resume, 0);
        rst_n = 1'b1;
        step();

        for (int i = 0; i < 6; i++) begin
            enter_halt(VECS[i].req, VECS[i].be, $sformatf("vec%0d", i));
            if (VECS[i].mask_first) begin
                intr = 1'b1;
                if_flag = 1'b0;
                step();
                chk("R7 masked stays halted", halted, 1);
                chk("R7 masked no pulse", resume, 0);
            end
            intr = 1'b0;
            case (VECS[i].wake)
                2'd1: begin intr = 1'b1; if_flag = 1'b1; end
                2'd2: nmi = 1'b1;
                default: reset_wake = 1'b1;
            endcase
            step();
            intr = 1'b0; if_flag = 1'b0; reset_wake = 1'b0; nmi = 1'b0;
            chk("R10 pulse", resume, 1);
            chk("R10 src", resume_src, VECS[i].src);
            chk("R10 leaves halt", halted, 0);
            step();
            chk("R10 pulse one clock", resume, 0);
        end

        // R6: requests ignored while halted; R8: steady nmi ignored
        nmi = 1'b1;
        step();
        enter_halt(1, 4'b1011, "steady");
        shut_req = 1'b1;
        step();
        shut_req = 1'b0;
        chk("R6 request ignored halted", ads_n, 1);
        chk("R8 steady nmi no wake", halted, 1);
        step();
        chk("R8 steady nmi no pulse", resume, 0);
        nmi = 1'b0;
        step();
        chk("R8 nmi low still halted", halted, 1);
        nmi = 1'b1;
        step();
        nmi = 1'b0;
        chk("R8 nmi edge wakes", {resume, resume_src}, 3'b110);

        // R9: reset priority over nmi and intr
        step();
        enter_halt(2, 4'b1110, "prio");
        reset_wake = 1'b1; nmi = 1'b1; intr = 1'b1; if_flag = 1'b1;
        step();
        reset_wake = 1'b0; nmi = 1'b0; intr = 1'b0; if_flag = 1'b0;
        chk("R9 reset priority", {resume, resume_src}, 3'b111);

        // R9: reset_wake aborts a stalled cycle, R6: no new cycle during busy
        step();
        halt_req = 1'b1;
        step();
        halt_req = 1'b0;
        step();
        shut_req = 1'b1;
        step();
        shut_req = 1'b0;
        chk("R6 no new strobe while busy", ads_n, 1);
        chk("R5 lanes held", be_n, 4'b1011);
        reset_wake = 1'b1;
        step();
        reset_wake = 1'b0;
        chk("R9 abort idle be", be_n, 4'hF);
        chk("R9 abort no pulse", resume, 0);
        rdy_n = 1'b0;
        step();
        rdy_n = 1'b1;
        chk("R9 abort not halted", halted, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule